// File: doc/BRIEF.md
# Return-Address Stack Controller

This block keeps the hardware return-address stack of a small processor core. Each cycle it may take one request: a push of the current program counter (from a subroutine call or an explicit push), a pop (from a return or an explicit pop), or a write to one or more bytes of the top entry. The core reads the top entry and the stack pointer straight from the outputs. Software can replace the value on top of the stack byte by byte, so it can plant data or a different return address before it returns.

Pushing onto a full stack and popping an empty one are faults. A fault sets a sticky flag. When a configuration input is high, the fault also raises a one-cycle reset request for the chip's reset generator. A reset request does not clear the flags. Only a software clear or the block's own power-on reset clears them.

Top module: `ret_stack_ctrl`

## Requirements
- R1: After power-on reset the stack pointer is 0, both flags are 0, the reset request is 0 and the top-entry output is 0.
- R2: A push (call_push_i or push_i) with the pointer below 31 raises the pointer by one and loads pc_i into the new top entry. Both results show after the next clock edge.
- R3: A pop (ret_pop_i or pop_i) with the pointer above 0 lowers the pointer by one. The entry pushed before the discarded one becomes the top, and its value is unchanged.
- R4: A push with the pointer at 31 sets the full flag and leaves the pointer and the top entry unchanged.
- R5: A pop with the pointer at 0 sets the underflow flag and leaves the pointer at 0. The top-entry output then reads 0.
- R6: tos_wr_i bit 0 writes tos_wdata_i into top-entry bits 7:0. Bit 1 writes bits 15:8. Bit 2 writes bits 20:16 from tos_wdata_i[4:0]. Only the selected bytes of the entry at the current pointer change, and they change at the next clock edge. The write is ignored when the pointer is 0 and in any cycle that also carries a push or a pop.
- R7: A push request and a pop request in the same cycle perform the push only. The pop is ignored.
- R8: With cfg_rst_en_i low a fault never raises rst_req_o. With it high, rst_req_o is high in the cycle after the edge that records the fault, and only while faults keep occurring.
- R9: The flags are sticky. flag_clr_i bit 1 clears the full flag and bit 0 clears the underflow flag, at the next edge. A fault in the same cycle wins over the clear. A reset request does not clear either flag.
- R10: The top-entry output reads 0 whenever the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset. Active low, asserted asynchronously and released synchronously inside the block |
| pc_i | input | 21 | Current program counter |
| call_push_i | input | 1 | Push requested by a call |
| push_i | input | 1 | Explicit push |
| ret_pop_i | input | 1 | Pop requested by a return |
| pop_i | input | 1 | Explicit pop |
| tos_wr_i | input | 3 | Byte write strobes for the top entry (bit 0 low, bit 1 high, bit 2 upper) |
| tos_wdata_i | input | 8 | Byte written into the top entry |
| flag_clr_i | input | 2 | Flag clear (bit 1 full, bit 0 underflow) |
| cfg_rst_en_i | input | 1 | Faults also request a reset |
| tos_o | output | 21 | Top entry (0 when the stack is empty) |
| sp_o | output | 5 | Stack pointer (0 means empty) |
| full_o | output | 1 | Sticky full flag |
| unf_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Every result of a request is due exactly one clock edge after the request is sampled: the pointer, the top entry, both flags and the reset request. The bench applies each request at a falling edge and moves its queue-based model forward at the same moment. At the following falling edge it compares all outputs with the model, so each check samples half a cycle after the edge that should have produced the change. Directed runs fill the stack to 31, overflow it, rewrite the top bytes, drain it and underflow it. Random traffic biased first toward pushes and then toward pops follows, with same-cycle push and pop requests, flag clears and a toggling configuration input.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  // One request is served per cycle, picked by fixed priority in the top.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_TOSW = 2'd3
  } stk_op_e;
endpackage

// File: rtl/ret_stack_rst_sync.sv
module ret_stack_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic             cfg_rst_en_i,
  input  logic [1:0]       flag_clr_i,
  output logic [PTR_W-1:0] sp_o,
  output logic             full_o,
  output logic             unf_o,
  output logic             rst_req_o
);
  localparam logic [PTR_W-1:0] SP_MAX = PTR_W'(DEPTH);

  logic [PTR_W-1:0] sp_q, sp_d;
  logic             sp_en;
  logic             full_q, full_d, unf_q, unf_d, req_q, req_d;
  logic             at_top, at_bot, ovf, udf;

  assign at_top = (sp_q == SP_MAX);
  assign at_bot = (sp_q == '0);
  assign ovf    = (op_i == OP_PUSH) && at_top;
  assign udf    = (op_i == OP_POP)  && at_bot;

  always_comb begin
    sp_en = 1'b0;
    sp_d  = sp_q;
    if (op_i == OP_PUSH && !at_top) begin
      sp_en = 1'b1;
      sp_d  = sp_q + 1'b1;
    end else if (op_i == OP_POP && !at_bot) begin
      sp_en = 1'b1;
      sp_d  = sp_q - 1'b1;
    end
    // a fault in the same cycle wins over a software clear
    full_d = ovf | (full_q & ~flag_clr_i[1]);
    unf_d  = udf | (unf_q  & ~flag_clr_i[0]);
    req_d  = cfg_rst_en_i & (ovf | udf);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= '0;
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (sp_en) sp_q <= sp_d;
      full_q <= full_d;
      unf_q  <= unf_d;
      req_q  <= req_d;
    end
  end

  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign unf_o     = unf_q;
  assign rst_req_o = req_q;

  // R3: pop on a non-empty stack lowers the pointer
  a_r3_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && !at_bot) |=> (sp_q == $past(sp_q) - 1'b1));
  // R4: overflow sets the flag and holds the pointer
  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && at_top) |=> (full_q && $stable(sp_q)));
  // R5: underflow sets the flag and keeps the pointer at zero
  a_r5_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && at_bot) |=> (unf_q && sp_q == '0));
  // R8: no reset request while the option is off
  a_r8_no_req_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_en_i |=> !req_q);
  // R9: flags stay set until cleared
  a_r9_full_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !flag_clr_i[1]) |=> full_q);
  a_r9_unf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !flag_clr_i[0]) |=> unf_q);
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem
  import ret_stack_pkg::*;
#(
  parameter int DEPTH  = 31,
  parameter int ADDR_W = 21,
  parameter int PTR_W  = $clog2(DEPTH + 1),
  parameter int NBYTES = (ADDR_W + 7) / 8
) (
  input  logic              clk_i,
  input  stk_op_e           op_i,
  input  logic [PTR_W-1:0]  sp_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [NBYTES-1:0] tos_wr_i,
  input  logic [7:0]        tos_wdata_i,
  output logic [ADDR_W-1:0] tos_o
);
  localparam logic [PTR_W-1:0] SP_MAX = PTR_W'(DEPTH);

  logic [ADDR_W-1:0] mem_q [1:DEPTH];
  logic [ADDR_W-1:0] rd_data, merged, wr_data;
  logic [PTR_W-1:0]  wr_idx;
  logic              wr_en;

  // read the entry the pointer addresses; empty stack reads zero
  always_comb begin
    rd_data = '0;
    for (int e = 1; e <= DEPTH; e++) begin
      if (sp_i == PTR_W'(e)) rd_data = mem_q[e];
    end
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      merged[i] = tos_wr_i[i / 8] ? tos_wdata_i[i % 8] : rd_data[i];
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = sp_i;
    wr_data = merged;
    if (op_i == OP_PUSH && sp_i != SP_MAX) begin
      wr_en   = 1'b1;
      wr_idx  = sp_i + 1'b1;
      wr_data = pc_i;
    end else if (op_i == OP_TOSW && sp_i != '0) begin
      wr_en   = 1'b1;
    end
  end

  for (genvar g = 1; g <= DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (wr_en && wr_idx == PTR_W'(g)) mem_q[g] <= wr_data;
    end
  end

  assign tos_o = rd_data;
endmodule

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH  = 31,
  parameter int ADDR_W = 21,
  parameter int PTR_W  = $clog2(DEPTH + 1),
  parameter int NBYTES = (ADDR_W + 7) / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              call_push_i,
  input  logic              push_i,
  input  logic              ret_pop_i,
  input  logic              pop_i,
  input  logic [NBYTES-1:0] tos_wr_i,
  input  logic [7:0]        tos_wdata_i,
  input  logic [1:0]        flag_clr_i,
  input  logic              cfg_rst_en_i,
  output logic [ADDR_W-1:0] tos_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              full_o,
  output logic              unf_o,
  output logic              rst_req_o
);
  localparam logic [PTR_W-1:0] SP_MAX = PTR_W'(DEPTH);

  logic    rst_s_n;
  logic    push_req, pop_req, tosw_req;
  stk_op_e op;

  ret_stack_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s_n)
  );

  assign push_req = call_push_i | push_i;
  assign pop_req  = ret_pop_i | pop_i;
  assign tosw_req = |tos_wr_i;

  // fixed priority: push over pop over top-entry write
  always_comb begin
    if (push_req)      op = OP_PUSH;
    else if (pop_req)  op = OP_POP;
    else if (tosw_req) op = OP_TOSW;
    else               op = OP_NONE;
  end

  ret_stack_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_s_n),
    .op_i         (op),
    .cfg_rst_en_i (cfg_rst_en_i),
    .flag_clr_i   (flag_clr_i),
    .sp_o         (sp_o),
    .full_o       (full_o),
    .unf_o        (unf_o),
    .rst_req_o    (rst_req_o)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .NBYTES(NBYTES)) u_mem (
    .clk_i       (clk_i),
    .op_i        (op),
    .sp_i        (sp_o),
    .pc_i        (pc_i),
    .tos_wr_i    (tos_wr_i),
    .tos_wdata_i (tos_wdata_i),
    .tos_o       (tos_o)
  );

  // R2: a push on a non-full stack shows the pushed PC on top
  a_r2_push_loads_pc: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (push_req && sp_o != SP_MAX) |=> (tos_o == $past(pc_i)));
  // R7: simultaneous push and pop acts as a push
  a_r7_push_wins: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (push_req && pop_req && sp_o != SP_MAX) |=> (sp_o == $past(sp_o) + 1'b1));
  // R6: a low-byte-only write leaves the upper bits alone
  a_r6_low_byte_only: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (!push_req && !pop_req && tos_wr_i == NBYTES'(1) && sp_o != '0)
      |=> (tos_o[ADDR_W-1:8] == $past(tos_o[ADDR_W-1:8]) && tos_o[7:0] == $past(tos_wdata_i)));
  // R10: empty stack reads zero
  a_r10_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (sp_o == '0) |-> (tos_o == '0));
endmodule

// File: tb/ret_stack_ctrl_test.sv
module ret_stack_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [20:0] pc;
  logic        call_push, push, ret_pop, pop;
  logic [2:0]  tos_wr;
  logic [7:0]  tos_wdata;
  logic [1:0]  flag_clr;
  logic        cfg;
  logic [20:0] tos;
  logic [4:0]  sp;
  logic        full, unf, rst_req;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 0;

  int m_stk[$];
  bit m_full, m_unf, m_req;
  string tag_op, tag_tos;

  always #5 clk = ~clk;

  ret_stack_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .call_push_i(call_push), .push_i(push),
    .ret_pop_i(ret_pop), .pop_i(pop), .tos_wr_i(tos_wr), .tos_wdata_i(tos_wdata),
    .flag_clr_i(flag_clr), .cfg_rst_en_i(cfg), .tos_o(tos), .sp_o(sp),
    .full_o(full), .unf_o(unf), .rst_req_o(rst_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_tos();
    return (m_stk.size() == 0) ? 0 : m_stk[$];
  endfunction

  task automatic compare();
    chk(tag_op, "sp", int'(sp), m_stk.size());
    chk(tag_tos, "tos", int'(tos), exp_tos());
    chk("R9", "full", int'(full), int'(m_full));
    chk("R9", "unf", int'(unf), int'(m_unf));
    chk("R8", "rst_req", int'(rst_req), int'(m_req));
  endtask

  // called at a falling edge: drive, update the model, wait, compare
  task automatic step(bit cp, bit ph, bit rp, bit pp, logic [2:0] wr, logic [7:0] wd,
                      logic [1:0] clr, bit c, logic [20:0] p);
    bit do_push, do_pop, ovf, udf;
    call_push = cp; push = ph; ret_pop = rp; pop = pp;
    tos_wr = wr; tos_wdata = wd; flag_clr = clr; cfg = c; pc = p;
    do_push = cp | ph;
    do_pop  = (rp | pp) & ~do_push;
    ovf = 0; udf = 0;
    if (do_push) begin
      if (m_stk.size() < 31) begin
        m_stk.push_back(int'(p));
        tag_op = (rp | pp) ? "R7" : "R2";
      end else begin
        ovf = 1; tag_op = "R4";
      end
    end else if (do_pop) begin
      if (m_stk.size() > 0) begin
        void'(m_stk.pop_back());
        tag_op = "R3";
      end else begin
        udf = 1; tag_op = "R5";
      end
    end else if (wr != 0) begin
      tag_op = "R6";
      if (m_stk.size() > 0) begin
        int v = m_stk[$];
        if (wr[0]) v = (v & ~32'h0000FF) | int'(wd);
        if (wr[1]) v = (v & ~32'h00FF00) | (int'(wd) << 8);
        if (wr[2]) v = (v & ~32'h1F0000) | ((int'(wd) & 32'h1F) << 16);
        m_stk[$] = v;
      end
    end else begin
      tag_op = "R9";
    end
    tag_tos = (m_stk.size() == 0) ? "R10" : tag_op;
    m_full = ovf | (m_full & ~clr[1]);
    m_unf  = udf | (m_unf  & ~clr[0]);
    m_req  = c & (ovf | udf);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(bit c);
    step(0, 0, 0, 0, 3'b000, 8'h00, 2'b00, c, 21'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    call_push = 0; push = 0; ret_pop = 0; pop = 0;
    tos_wr = 0; tos_wdata = 0; flag_clr = 0; cfg = 0; pc = 0;
    m_full = 0; m_unf = 0; m_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "sp", int'(sp), 0);
    chk("R1", "tos", int'(tos), 0);
    chk("R1", "flags", int'({full, unf}), 0);
    chk("R1", "rst_req", int'(rst_req), 0);

    // R2: fill the stack with calls and explicit pushes
    for (int i = 0; i < 31; i++)
      step(i[0], ~i[0], 0, 0, 3'b000, 8'h00, 2'b00, 0, 21'h10000 + 21'(i * 37));
    // R4: overflow with reset option off, then on
    step(1, 0, 0, 0, 3'b000, 8'h00, 2'b00, 0, 21'h1ABCD);
    step(0, 1, 0, 0, 3'b000, 8'h00, 2'b00, 1, 21'h0BEEF);
    idle(1);
    // R6: byte writes to the top entry
    step(0, 0, 0, 0, 3'b001, 8'h5A, 2'b00, 0, 21'h0);
    step(0, 0, 0, 0, 3'b010, 8'hC3, 2'b00, 0, 21'h0);
    step(0, 0, 0, 0, 3'b100, 8'hFF, 2'b00, 0, 21'h0);
    // R6: write together with a pop is dropped
    step(0, 0, 1, 0, 3'b111, 8'h11, 2'b00, 0, 21'h0);
    // R9: clear full
    step(0, 0, 0, 0, 3'b000, 8'h00, 2'b10, 0, 21'h0);
    // R3: drain with returns and explicit pops
    for (int i = 0; i < 30; i++)
      step(0, 0, i[0], ~i[0], 3'b000, 8'h00, 2'b00, 0, 21'h0);
    // R5, R8: underflow with option on, then off
    step(0, 0, 0, 1, 3'b000, 8'h00, 2'b00, 1, 21'h0);
    step(0, 0, 1, 0, 3'b000, 8'h00, 2'b00, 0, 21'h0);
    // R6: write on empty stack ignored; R10 empty reads zero
    step(0, 0, 0, 0, 3'b111, 8'h77, 2'b00, 0, 21'h0);
    // R9: fault wins over clear
    step(0, 0, 0, 1, 3'b000, 8'h00, 2'b01, 0, 21'h0);
    step(0, 0, 0, 0, 3'b000, 8'h00, 2'b01, 0, 21'h0);
    // R7: push and pop together
    step(1, 0, 1, 0, 3'b000, 8'h00, 2'b00, 0, 21'h01234);
    step(0, 1, 0, 1, 3'b000, 8'h00, 2'b00, 0, 21'h05678);

    // random traffic: push-heavy, then pop-heavy
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 600; n++) begin
        int r = int'($urandom_range(0, 15));
        bit bp = (ph[0] == 0) ? (r < 8) : (r < 4);
        bit bq = (ph[0] == 0) ? (r >= 6 && r < 10) : (r >= 3 && r < 12);
        logic [2:0] w = (r >= 12) ? 3'($urandom) : 3'b000;
        logic [1:0] cl = ($urandom_range(0, 9) == 0) ? 2'($urandom) : 2'b00;
        bit which = bit'($urandom);
        step(bp & which, bp & ~which, bq & which, bq & ~which, w, 8'($urandom),
             cl, bit'($urandom), 21'($urandom));
      end
    end
    idle(0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ntests++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule